// File: doc/BRIEF.md
# Power-Gating Sleep/Wake Sequencer

This block is an always-on controller for a single switchable power domain. A sleep request walks the domain through a fixed shutdown order: stop its clock, clamp its outputs, capture retained state, hold it in reset, and finally open the power switch. A wake request runs the mirrored order. The switch is closed first, and the controller waits for the switch acknowledge before it restores retained state. It then releases reset, drops the clamp, and restarts the clock.

Each step holds its control pattern for a programmable number of cycles. One dwell count applies to the shutdown steps and a separate one to the wake steps. The controller never abandons a sequence part-way. A request for the opposite direction that arrives during a sequence is remembered and served once the current sequence has reached its end state. The block also reports a coarse power state for the domain. It contains the output clamp for the domain's data bus, which forces every bit to 1 while isolation is active.

Top module: `pg_seq_ctrl`

## Requirements
- R1: After reset the controller sits in the powered-down end state with pwr_state_o = 0, clk_en_o = 0, iso_no = 0, save_no = 1, rst_no = 0, pwr_on_no = 1, restore_o = 0.
- R2: In the on state {clk_en_o, iso_no, save_no, rst_no, pwr_on_no, restore_o} = 111100. After sleep_req_i is sampled high, the pattern steps through 011100 (clock stopped), 001100 (isolated), 000100 (save), 001000 (reset), 001010 (switch open), and each pattern is held for entry_dwell_i + 1 cycles. The pattern then stays at 001010 in the off state.
- R3: On wake, pwr_on_no goes low at once with pattern 001000. restore_o (pattern 001001) rises on the (exit_dwell_i + 1)-th rising edge at which pwr_ack_i is sampled high. Before that edge the pattern stays at 001000 regardless of how long the acknowledge takes.
- R4: After restore, the wake sequence releases reset (001100), then releases isolation (011100), then enables the clock (111100). Each of the restore and later steps lasts exit_dwell_i + 1 cycles, after which the controller is on.
- R5: save_no is active low and is low only in the save step. restore_o is active high and is high only in the restore step. Save happens only while the domain is isolated, powered and out of reset.
- R6: dom_data_o equals all ones whenever iso_no is low and equals dom_data_i whenever iso_no is high.
- R7: pwr_state_o encodes 0 = OFF (off end state only), 1 = BOOT (any sequence step), 2 = ON (on end state only). It never moves directly between OFF and ON.
- R8: A sleep request seen during a wake sequence is held. The sequence completes, the on state lasts one cycle, and shutdown then begins. The same applies to a wake request during shutdown: the off state lasts one cycle and wake then begins.
- R9: wake_req_i has no effect in the on state. sleep_req_i has no effect in the off state and is not remembered for later.
- R10: A dwell value of zero gives one cycle per step, both on shutdown and on wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Request to power the domain down |
| wake_req_i | input | 1 | Request to power the domain up |
| pwr_ack_i | input | 1 | Power switch reports domain supply good |
| entry_dwell_i | input | CNT_W | Extra hold cycles per shutdown step |
| exit_dwell_i | input | CNT_W | Extra hold cycles per wake step |
| dom_data_i | input | DATA_W | Data leaving the switchable domain |
| dom_data_o | output | DATA_W | Clamped domain data for the live logic |
| clk_en_o | output | 1 | Domain clock enable, active high |
| iso_no | output | 1 | Isolation, active low |
| save_no | output | 1 | Retention save, active low |
| rst_no | output | 1 | Domain reset, active low |
| pwr_on_no | output | 1 | Power switch enable, active low |
| restore_o | output | 1 | Retention restore, active high |
| pwr_state_o | output | 2 | Domain power state: 0 OFF, 1 BOOT, 2 ON |

## Verification
Full sleep-then-wake cycles are run with several pairs of dwell values, including zero, and with the acknowledge delayed by different amounts. A wrong per-step length, a swapped step or a restore that does not wait for the acknowledge shows up as a pattern mismatch in a specific cycle. Requests that arrive during a sequence in the opposite direction show whether the controller defers or aborts. Requests in the opposite end state show whether stray requests are ignored or wrongly latched. The data clamp is compared in both end states with a non-uniform data word, so a stuck or inverted bit is visible.

// File: rtl/pg_seq_pkg.sv
package pg_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF     = 4'd0,
    ST_PWRON   = 4'd1,
    ST_RESTORE = 4'd2,
    ST_RSTREL  = 4'd3,
    ST_ISOREL  = 4'd4,
    ST_CLKON   = 4'd5,
    ST_ON      = 4'd6,
    ST_CLKOFF  = 4'd7,
    ST_ISO     = 4'd8,
    ST_SAVE    = 4'd9,
    ST_RST     = 4'd10,
    ST_PWROFF  = 4'd11
  } step_e;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_BOOT = 2'd1,
    PS_ON   = 2'd2
  } pwr_state_e;

  typedef struct packed {
    logic clk_en;
    logic iso_n;
    logic save_n;
    logic rst_n;
    logic pwr_on_n;
    logic restore;
  } ctl_t;

  function automatic logic is_entry(step_e s);
    return (s == ST_CLKOFF) || (s == ST_ISO) || (s == ST_SAVE) ||
           (s == ST_RST) || (s == ST_PWROFF);
  endfunction

  function automatic logic is_exit(step_e s);
    return (s == ST_PWRON) || (s == ST_RESTORE) || (s == ST_RSTREL) ||
           (s == ST_ISOREL) || (s == ST_CLKON);
  endfunction

endpackage

// File: rtl/pg_dwell_timer.sv
module pg_dwell_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R10: once expired, the timer stays expired until reloaded
  a_r10_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o);

endmodule

// File: rtl/pg_step_fsm.sv
module pg_step_fsm
  import pg_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_req_i,
  input  logic             wake_req_i,
  input  logic             pwr_ack_i,
  input  logic [CNT_W-1:0] entry_dwell_i,
  input  logic [CNT_W-1:0] exit_dwell_i,
  input  logic             done_i,
  output step_e            step_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             tick_o
);

  step_e step_q, step_d;
  logic  pend_sleep_q, pend_wake_q;
  logic  adv;

  always_comb begin
    tick_o = (step_q != ST_PWRON) || pwr_ack_i;
    adv    = done_i && tick_o;
    step_d = step_q;
    unique case (step_q)
      ST_OFF:     if (wake_req_i || pend_wake_q)   step_d = ST_PWRON;
      ST_PWRON:   if (adv) step_d = ST_RESTORE;
      ST_RESTORE: if (adv) step_d = ST_RSTREL;
      ST_RSTREL:  if (adv) step_d = ST_ISOREL;
      ST_ISOREL:  if (adv) step_d = ST_CLKON;
      ST_CLKON:   if (adv) step_d = ST_ON;
      ST_ON:      if (sleep_req_i || pend_sleep_q) step_d = ST_CLKOFF;
      ST_CLKOFF:  if (adv) step_d = ST_ISO;
      ST_ISO:     if (adv) step_d = ST_SAVE;
      ST_SAVE:    if (adv) step_d = ST_RST;
      ST_RST:     if (adv) step_d = ST_PWROFF;
      ST_PWROFF:  if (adv) step_d = ST_OFF;
      default:    step_d = ST_OFF;
    endcase
  end

  assign load_o     = (step_d != step_q);
  assign load_val_o = is_entry(step_d) ? entry_dwell_i : exit_dwell_i;
  assign step_o     = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q       <= ST_OFF;
      pend_sleep_q <= 1'b0;
      pend_wake_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      // opposite-direction requests are deferred, never abort a sequence
      if (step_q == ST_ON && step_d == ST_CLKOFF) pend_sleep_q <= 1'b0;
      else if (sleep_req_i && is_exit(step_q))   pend_sleep_q <= 1'b1;
      if (step_q == ST_OFF && step_d == ST_PWRON) pend_wake_q <= 1'b0;
      else if (wake_req_i && is_entry(step_q))   pend_wake_q <= 1'b1;
    end
  end

  // R3: power-up step cannot be left while the switch has not acknowledged
  a_r3_pwron_waits_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_PWRON && !pwr_ack_i) |=> (step_q == ST_PWRON));

  // R8: shutdown, once started, only moves forward
  a_r8_no_abort_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_SAVE) |=> (step_q == ST_SAVE || step_q == ST_RST));

  // R8: wake, once started, only moves forward
  a_r8_no_abort_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_RESTORE) |=> (step_q == ST_RESTORE || step_q == ST_RSTREL));

endmodule

// File: rtl/pg_ctl_decode.sv
module pg_ctl_decode
  import pg_seq_pkg::*;
(
  input  step_e      step_i,
  output ctl_t       ctl_o,
  output pwr_state_e state_o
);

  always_comb begin
    // default: powered-down pattern
    ctl_o = '{clk_en: 1'b0, iso_n: 1'b0, save_n: 1'b1, rst_n: 1'b0,
              pwr_on_n: 1'b1, restore: 1'b0};
    state_o = PS_BOOT;
    unique case (step_i)
      ST_OFF:     state_o = PS_OFF;
      ST_ON: begin
        ctl_o   = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
        state_o = PS_ON;
      end
      ST_CLKOFF:  ctl_o = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
      ST_ISO:     ctl_o = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
      ST_SAVE:    ctl_o = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
      ST_RST:     ctl_o = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
      ST_PWROFF:  ctl_o = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
      ST_PWRON:   ctl_o = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
      ST_RESTORE: ctl_o = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
      ST_RSTREL:  ctl_o = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
      ST_ISOREL:  ctl_o = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
      ST_CLKON:   ctl_o = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
      default:    state_o = PS_BOOT;
    endcase
  end

endmodule

// File: rtl/pg_iso_clamp.sv
module pg_iso_clamp #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              iso_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign data_o[b] = data_i[b] | ~iso_ni;
  end

endmodule

// File: rtl/pg_seq_ctrl.sv
module pg_seq_ctrl
  import pg_seq_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic              wake_req_i,
  input  logic              pwr_ack_i,
  input  logic [CNT_W-1:0]  entry_dwell_i,
  input  logic [CNT_W-1:0]  exit_dwell_i,
  input  logic [DATA_W-1:0] dom_data_i,
  output logic [DATA_W-1:0] dom_data_o,
  output logic              clk_en_o,
  output logic              iso_no,
  output logic              save_no,
  output logic              rst_no,
  output logic              pwr_on_no,
  output logic              restore_o,
  output logic [1:0]        pwr_state_o
);

  step_e            step;
  logic             load, tick, done;
  logic [CNT_W-1:0] load_val;
  ctl_t             ctl;
  pwr_state_e       pstate;

  pg_step_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sleep_req_i  (sleep_req_i),
    .wake_req_i   (wake_req_i),
    .pwr_ack_i    (pwr_ack_i),
    .entry_dwell_i(entry_dwell_i),
    .exit_dwell_i (exit_dwell_i),
    .done_i       (done),
    .step_o       (step),
    .load_o       (load),
    .load_val_o   (load_val),
    .tick_o       (tick)
  );

  pg_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .tick_i    (tick),
    .done_o    (done)
  );

  pg_ctl_decode u_dec (
    .step_i (step),
    .ctl_o  (ctl),
    .state_o(pstate)
  );

  pg_iso_clamp #(.DATA_W(DATA_W)) u_clamp (
    .iso_ni(ctl.iso_n),
    .data_i(dom_data_i),
    .data_o(dom_data_o)
  );

  assign clk_en_o    = ctl.clk_en;
  assign iso_no      = ctl.iso_n;
  assign save_no     = ctl.save_n;
  assign rst_no      = ctl.rst_n;
  assign pwr_on_no   = ctl.pwr_on_n;
  assign restore_o   = ctl.restore;
  assign pwr_state_o = pstate;

  // R7: no direct jump between OFF and ON
  a_r7_no_skip_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd2) |-> ($past(pwr_state_o) != 2'd0));
  a_r7_no_skip_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_o == 2'd0) |-> ($past(pwr_state_o) != 2'd2));

  // R2: the clamp is only active while the clock is stopped
  a_r2_iso_clk_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iso_no |-> !clk_en_o);

  // R2: the switch is only open while clamped and in reset
  a_r2_off_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_on_no |-> (!iso_no && !rst_no && !clk_en_o));

  // R5: save happens isolated, powered and out of reset
  a_r5_save_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !save_no |-> (!iso_no && rst_no && !pwr_on_no && !restore_o));

  // R3: restore starts only after the switch acknowledged
  a_r3_restore_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restore_o) |-> ($past(pwr_ack_i) && !pwr_on_no));

endmodule

// File: tb/sim_pg_seq_ctrl.sv
`timescale 1ns/1ps
module sim_pg_seq_ctrl;

  localparam int CNT_W  = 8;
  localparam int DATA_W = 8;
  localparam logic [DATA_W-1:0] DPAT = 8'h5A;

  // {pwr_state, clk_en, iso_n, save_n, rst_n, pwr_on_n, restore}
  localparam logic [7:0] E_ON      = {2'd2, 6'b111100};
  localparam logic [7:0] E_CLKOFF  = {2'd1, 6'b011100};
  localparam logic [7:0] E_ISO     = {2'd1, 6'b001100};
  localparam logic [7:0] E_SAVE    = {2'd1, 6'b000100};
  localparam logic [7:0] E_RST     = {2'd1, 6'b001000};
  localparam logic [7:0] E_PWROFF  = {2'd1, 6'b001010};
  localparam logic [7:0] E_OFF     = {2'd0, 6'b001010};
  localparam logic [7:0] E_PWRON   = {2'd1, 6'b001000};
  localparam logic [7:0] E_RESTORE = {2'd1, 6'b001001};
  localparam logic [7:0] E_RSTREL  = {2'd1, 6'b001100};
  localparam logic [7:0] E_ISOREL  = {2'd1, 6'b011100};
  localparam logic [7:0] E_CLKON   = {2'd1, 6'b111100};

  // {entry dwell, exit dwell, ack delay (>=1)}
  localparam int NVEC = 4;
  localparam logic [11:0] VEC [NVEC] = '{
    {4'd0, 4'd0, 4'd1},
    {4'd2, 4'd1, 4'd3},
    {4'd1, 4'd3, 4'd1},
    {4'd3, 4'd2, 4'd5}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_req_i = 1'b0, wake_req_i = 1'b0, pwr_ack_i = 1'b0;
  logic [CNT_W-1:0]  entry_dwell_i = '0, exit_dwell_i = '0;
  logic [DATA_W-1:0] dom_data_i = DPAT;
  logic [DATA_W-1:0] dom_data_o;
  logic clk_en_o, iso_no, save_no, rst_no, pwr_on_no, restore_o;
  logic [1:0] pwr_state_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  pg_seq_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (
    .clk_i, .rst_ni, .sleep_req_i, .wake_req_i, .pwr_ack_i,
    .entry_dwell_i, .exit_dwell_i, .dom_data_i, .dom_data_o,
    .clk_en_o, .iso_no, .save_no, .rst_no, .pwr_on_no, .restore_o,
    .pwr_state_o
  );

  function automatic logic [7:0] obs();
    return {pwr_state_o, clk_en_o, iso_no, save_no, rst_no, pwr_on_no, restore_o};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic hold(input logic [7:0] exp, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1;
      chk({24'd0, obs()}, {24'd0, exp}, tag);
    end
  endtask

  // R2 / R10 shutdown; req=0 when a deferred request already exists
  task automatic do_sleep(input int de, input bit req);
    if (req) sleep_req_i = 1'b1;
    hold(E_CLKOFF, 1, "R2 clkoff");
    sleep_req_i = 1'b0;
    hold(E_CLKOFF, de, "R2 clkoff");
    hold(E_ISO, de + 1, "R2 iso");
    hold(E_SAVE, de + 1, "R5 save");
    hold(E_RST, de + 1, "R2 rst");
    hold(E_PWROFF, de + 1, "R2 pwroff");
    pwr_ack_i = 1'b0;
    hold(E_OFF, 1, "R7 off");
    chk({24'd0, dom_data_o}, {24'd0, 8'hFF}, "R6 clamp off");
  endtask

  // R3 / R4 wake
  task automatic do_wake(input int xd, input int ad, input bit req);
    if (req) wake_req_i = 1'b1;
    hold(E_PWRON, 1, "R3 pwron");
    wake_req_i = 1'b0;
    hold(E_PWRON, ad - 1, "R3 ack wait");
    pwr_ack_i = 1'b1;
    hold(E_PWRON, xd, "R3 ack dwell");
    hold(E_RESTORE, xd + 1, "R5 restore");
    hold(E_RSTREL, xd + 1, "R4 rstrel");
    hold(E_ISOREL, xd + 1, "R4 isorel");
    hold(E_CLKON, xd + 1, "R4 clkon");
    hold(E_ON, 1, "R7 on");
    chk({24'd0, dom_data_o}, {24'd0, DPAT}, "R6 pass on");
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk({24'd0, obs()}, {24'd0, E_OFF}, "R1 reset");
    chk({24'd0, dom_data_o}, {24'd0, 8'hFF}, "R1 R6 reset clamp");
    @(negedge clk_i) rst_ni = 1'b1;
    hold(E_OFF, 2, "R1 idle");

    // table walk: wake then sleep per vector (R2 R3 R4 R10)
    for (int v = 0; v < NVEC; v++) begin
      entry_dwell_i = CNT_W'(VEC[v][11:8]);
      exit_dwell_i  = CNT_W'(VEC[v][7:4]);
      do_wake(int'(VEC[v][7:4]), int'(VEC[v][3:0]), 1'b1);
      do_sleep(int'(VEC[v][11:8]), 1'b1);
    end

    entry_dwell_i = 8'd1;
    exit_dwell_i  = 8'd1;

    // R9: sleep in OFF is ignored and not remembered
    sleep_req_i = 1'b1;
    hold(E_OFF, 3, "R9 sleep in off");
    sleep_req_i = 1'b0;
    hold(E_OFF, 2, "R9 off stays");
    do_wake(1, 2, 1'b1);
    hold(E_ON, 3, "R9 no latched sleep");

    // R9: wake in ON is ignored
    wake_req_i = 1'b1;
    hold(E_ON, 3, "R9 wake in on");
    wake_req_i = 1'b0;
    hold(E_ON, 1, "R9 on stays");

    // R8: wake request during shutdown is deferred
    sleep_req_i = 1'b1;
    hold(E_CLKOFF, 1, "R8 clkoff");
    sleep_req_i = 1'b0;
    hold(E_CLKOFF, 1, "R8 clkoff");
    hold(E_ISO, 1, "R8 iso");
    wake_req_i = 1'b1;
    hold(E_ISO, 1, "R8 iso no abort");
    wake_req_i = 1'b0;
    hold(E_SAVE, 2, "R8 save");
    hold(E_RST, 2, "R8 rst");
    hold(E_PWROFF, 2, "R8 pwroff");
    pwr_ack_i = 1'b0;
    hold(E_OFF, 1, "R8 off one cycle");
    do_wake(1, 1, 1'b0);

    // R8: sleep request during wake is deferred
    sleep_req_i = 1'b1;
    hold(E_CLKOFF, 1, "R8 clkoff");
    sleep_req_i = 1'b0;
    hold(E_CLKOFF, 1, "R8 clkoff");
    hold(E_ISO, 2, "R8 iso");
    hold(E_SAVE, 2, "R8 save");
    hold(E_RST, 2, "R8 rst");
    hold(E_PWROFF, 2, "R8 pwroff");
    pwr_ack_i = 1'b0;
    hold(E_OFF, 1, "R8 off");
    wake_req_i = 1'b1;
    hold(E_PWRON, 1, "R8 pwron");
    wake_req_i = 1'b0;
    pwr_ack_i = 1'b1;
    hold(E_PWRON, 1, "R8 pwron");
    hold(E_RESTORE, 1, "R8 restore");
    sleep_req_i = 1'b1;
    hold(E_RESTORE, 1, "R8 restore no abort");
    sleep_req_i = 1'b0;
    hold(E_RSTREL, 2, "R8 rstrel");
    hold(E_ISOREL, 2, "R8 isorel");
    hold(E_CLKON, 2, "R8 clkon");
    hold(E_ON, 1, "R8 on one cycle");
    do_sleep(1, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule